// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler

This block orders the erase work of a flash array built from eight 64 KB sectors. The sector is chosen by the top three address bits. A command decoder ahead of it hands over one-cycle command pulses: a sector-erase write that carries a sector number, a chip erase, an erase suspend, an erase resume, and a pulse for a reset or any other command. Each sector-erase write adds its sector to a pending set. It also restarts an acceptance window, so software can queue as many sectors as it likes, provided each write follows the previous one closely enough.

When the window runs out with no new sector-erase write, the block works through the pending set. It skips every sector flagged in the protection mask and takes the remaining sectors from the lowest number upward. Each sector first goes through a zero-fill phase and then an electrical erase phase. Both phases are modelled only as cycle counts. Any command that does not belong to the sequence discards a collection that is still open. A suspend can freeze the work either before it starts or while it runs. A watchdog budget for each sector raises a sticky failure flag.

Top module: `sector_erase_sched`

## Requirements
- R1: After reset, busy, window_open, suspended, done, timeout_err, pre_prog and cur_sector all read 0.
- R2: A sector-erase pulse while idle opens the window and selects sector `1 << cmd_sector`. Every further sector-erase pulse while the window is open adds its sector and restarts the window. window_open stays high for exactly WIN_CYC cycles after the cycle of the last such pulse.
- R3: When the window expires, busy rises. The selected sectors that are not protected are processed one at a time in ascending sector number, each for PREP_CYC+ERASE_CYC cycles. cur_sector shows the sector being processed and reads 0 whenever busy is low.
- R4: pre_prog is high for the first PREP_CYC cycles of each sector (the zero-fill phase) and low for its last ERASE_CYC cycles.
- R5: A sector whose bit is set in prot_mask when the erase is committed is never processed, and neither is a sector that was not selected. If no sector is left, done pulses in the cycle right after expiry and busy never rises.
- R6: done is a single-cycle pulse in the cycle after the last sector finishes, and busy is low in that same cycle.
- R7: A reset/other pulse or a chip-erase pulse while the window is open closes the window and drops the collected sectors. No erase and no done follow.
- R8: A suspend while the window is open closes it at once and enters the suspended state (suspended and busy high, with the first sector in its zero-fill phase). Nothing advances until a resume, which starts the erase from its beginning.
- R9: A suspend during a sector erase lets the erase keep running for SUSP_LAT more cycles. suspended is then high from the (SUSP_LAT+1)-th cycle after the pulse, and progress is frozen until a resume continues it. A suspend while a suspend is already pending or in effect is ignored, and so is a resume while the erase is running.
- R10: A chip-erase pulse while idle starts processing all unprotected sectors at once, with no window. A suspend during a chip erase is ignored.
- R11: If one sector is still running after MAX_CYC cycles, processing stops, busy falls, no done is given, and timeout_err goes high. timeout_err stays high through later erases until a reset/other pulse.
- R12: A reset/other pulse during an erase, or while suspended, ends all activity at once without a done. A resume that arrives afterwards has no effect.
- R13: A sector-erase pulse in the last open cycle of the window (the cycle in which it would otherwise expire) restarts the window instead of letting the erase start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sec_erase | input | 1 | Sector-erase command pulse |
| cmd_sector | input | 3 | Sector number carried by the sector-erase pulse |
| cmd_chip_erase | input | 1 | Chip-erase command pulse |
| cmd_suspend | input | 1 | Erase-suspend command pulse |
| cmd_resume | input | 1 | Erase-resume command pulse |
| cmd_other | input | 1 | Reset or any other command pulse |
| prot_mask | input | 8 | One bit per sector; 1 = protected |
| busy | output | 1 | Erase committed (running, suspend pending, or suspended) |
| window_open | output | 1 | Acceptance window is collecting sectors |
| suspended | output | 1 | Erase is frozen by a suspend |
| cur_sector | output | 3 | Sector being processed (0 when not busy) |
| pre_prog | output | 1 | Current sector is in its zero-fill phase |
| done | output | 1 | One-cycle pulse when all work completes |
| timeout_err | output | 1 | Sticky per-sector budget failure |

## Verification
Two events can land in the same cycle: window expiry and the arrival of another command. The first case is a sector-erase pulse placed in the exact last open cycle of the window. The bench counts the cycles from the previous write, and it must see the window stay open for another full span, with the erase starting later on the first sector written. The second case is a suspend that reaches a running erase. The bench reads the moment suspended rises and then the number of cycles from resume to done. From those two counts it checks that the erase kept advancing for exactly the latency span and not a cycle more.

// File: rtl/sched_pkg.sv
package sched_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WIN   = 3'd1,
        S_RUN   = 3'd2,
        S_SPEND = 3'd3,
        S_SUSP  = 3'd4
    } sched_st_e;
endpackage

// File: rtl/sched_lowest.sv
module sched_lowest #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx
);
    timeunit 1ns;
    timeprecision 1ps;

    // lowest set bit wins: scan from the top so lower indices overwrite
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/sched_countdown.sv
module sched_countdown #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R2: the countdown rests at zero until it is reloaded
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
    // R2: a reload takes effect on the next edge
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/sector_erase_sched.sv
module sector_erase_sched
    import sched_pkg::*;
#(
    parameter int N_SECT    = 8,
    parameter int WIN_CYC   = 16000,
    parameter int SUSP_LAT  = 3000,
    parameter int PREP_CYC  = 1000,
    parameter int ERASE_CYC = 4000,
    parameter int MAX_CYC   = 8000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_sec_erase,
    input  logic [$clog2(N_SECT)-1:0] cmd_sector,
    input  logic                      cmd_chip_erase,
    input  logic                      cmd_suspend,
    input  logic                      cmd_resume,
    input  logic                      cmd_other,
    input  logic [N_SECT-1:0]         prot_mask,
    output logic                      busy,
    output logic                      window_open,
    output logic                      suspended,
    output logic [$clog2(N_SECT)-1:0] cur_sector,
    output logic                      pre_prog,
    output logic                      done,
    output logic                      timeout_err
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SW      = $clog2(N_SECT);
    localparam int TOTAL   = PREP_CYC + ERASE_CYC;
    localparam int CNT_TOP = (TOTAL > MAX_CYC) ? TOTAL : MAX_CYC;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam int WW      = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int LW      = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;

    typedef struct packed {
        sched_st_e          st;
        logic [N_SECT-1:0]  mask;
        logic [N_SECT-1:0]  work;
        logic [CW-1:0]      cnt;
        logic               chip;
        logic               done;
        logic               tmo;
    } sched_t;

    sched_t d, q;

    logic              win_load, win_zero;
    logic              sl_load, sl_zero;
    logic [SW-1:0]     cur_idx;
    logic [N_SECT-1:0] sel_bit, cur_bit;

    assign sel_bit = N_SECT'(1) << cmd_sector;
    assign cur_bit = N_SECT'(1) << cur_idx;

    sched_lowest #(.N(N_SECT), .W(SW)) u_pick (
        .vec (q.work),
        .idx (cur_idx)
    );

    sched_countdown #(.WIDTH(WW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (WW'(WIN_CYC - 1)),
        .zero     (win_zero)
    );

    sched_countdown #(.WIDTH(LW)) u_slat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sl_load),
        .load_val (LW'(SUSP_LAT - 1)),
        .zero     (sl_zero)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        win_load = 1'b0;
        sl_load  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (cmd_other) begin
                    d.tmo = 1'b0;
                end else if (cmd_chip_erase) begin
                    d.chip = 1'b1;
                    d.cnt  = '0;
                    d.work = ~prot_mask;
                    if (~prot_mask == '0) d.done = 1'b1;
                    else                  d.st   = S_RUN;
                end else if (cmd_sec_erase) begin
                    d.mask   = sel_bit;
                    d.st     = S_WIN;
                    win_load = 1'b1;
                end
            end
            S_WIN: begin
                if (cmd_other || cmd_chip_erase) begin
                    d.st   = S_IDLE;
                    d.mask = '0;
                    if (cmd_other) d.tmo = 1'b0;
                end else begin
                    d.mask = q.mask | (cmd_sec_erase ? sel_bit : '0);
                    if (cmd_suspend) begin
                        d.st   = S_SUSP;
                        d.work = d.mask & ~prot_mask;
                        d.mask = '0;
                        d.cnt  = '0;
                        d.chip = 1'b0;
                    end else if (cmd_sec_erase) begin
                        win_load = 1'b1;
                    end else if (win_zero) begin
                        d.work = q.mask & ~prot_mask;
                        d.mask = '0;
                        d.cnt  = '0;
                        d.chip = 1'b0;
                        if ((q.mask & ~prot_mask) == '0) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st = S_RUN;
                        end
                    end
                end
            end
            S_RUN, S_SPEND: begin
                if (cmd_other) begin
                    d.st   = S_IDLE;
                    d.mask = '0;
                    d.work = '0;
                    d.cnt  = '0;
                    d.tmo  = 1'b0;
                end else begin
                    if (q.st == S_RUN && cmd_suspend && !q.chip) begin
                        d.st    = S_SPEND;
                        sl_load = 1'b1;
                    end else if (q.st == S_SPEND && sl_zero) begin
                        d.st = S_SUSP;
                    end
                    if (q.cnt == CW'(TOTAL - 1)) begin
                        d.work = q.work & ~cur_bit;
                        d.cnt  = '0;
                        if ((q.work & ~cur_bit) == '0) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end
                    end else if (q.cnt == CW'(MAX_CYC - 1)) begin
                        d.st   = S_IDLE;
                        d.tmo  = 1'b1;
                        d.work = '0;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_SUSP: begin
                if (cmd_other) begin
                    d.st   = S_IDLE;
                    d.mask = '0;
                    d.work = '0;
                    d.cnt  = '0;
                    d.tmo  = 1'b0;
                end else if (cmd_resume) begin
                    if (q.work == '0) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = S_RUN;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st == S_RUN) || (q.st == S_SPEND) || (q.st == S_SUSP);
    assign window_open = (q.st == S_WIN);
    assign suspended   = (q.st == S_SUSP);
    assign cur_sector  = busy ? cur_idx : '0;
    assign pre_prog    = busy && (q.cnt < CW'(PREP_CYC));
    assign done        = q.done;
    assign timeout_err = q.tmo;

    // R13: a sector write while collecting keeps the window open next cycle
    p_retrig_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && cmd_sec_erase && !cmd_other && !cmd_chip_erase && !cmd_suspend)
        |=> window_open);
    // R6: the completion pulse never overlaps committed work
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: progress is frozen while suspended
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(suspended) && suspended) |-> (q.cnt == $past(q.cnt)));
    // R11: the failure flag only clears on a reset/other command
    p_tmo_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !cmd_other) |=> timeout_err);
    // R10: a chip erase cannot be suspended
    p_chip_nosusp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RUN && q.chip && cmd_suspend && !cmd_other) |=> !suspended);
    // R12: a reset/other command leaves nothing active
    p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_other |=> (!busy && !window_open));
endmodule

// File: tb/tb_sector_erase_sched.sv
module tb_sector_erase_sched;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W   = 4;
    localparam int LAT = 3;
    localparam int PRE = 2;
    localparam int ERS = 6;
    localparam int T   = PRE + ERS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec = 1'b0, chip = 1'b0, susp = 1'b0, resm = 1'b0, other = 1'b0;
    logic [2:0] sector = '0;
    logic [7:0] prot = '0;

    logic       busy, win, susd, pre, done, tmo;
    logic [2:0] cur;
    logic       busy_t, win_t, susd_t, pre_t, done_t, tmo_t;
    logic [2:0] cur_t;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sector_erase_sched #(.WIN_CYC(W), .SUSP_LAT(LAT), .PREP_CYC(PRE),
                         .ERASE_CYC(ERS), .MAX_CYC(64)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_sec_erase(sec), .cmd_sector(sector),
        .cmd_chip_erase(chip), .cmd_suspend(susp), .cmd_resume(resm),
        .cmd_other(other), .prot_mask(prot), .busy(busy), .window_open(win),
        .suspended(susd), .cur_sector(cur), .pre_prog(pre), .done(done),
        .timeout_err(tmo));

    sector_erase_sched #(.WIN_CYC(W), .SUSP_LAT(LAT), .PREP_CYC(PRE),
                         .ERASE_CYC(ERS), .MAX_CYC(3)) dut_to (
        .clk(clk), .rst_n(rst_n), .cmd_sec_erase(sec), .cmd_sector(sector),
        .cmd_chip_erase(chip), .cmd_suspend(susp), .cmd_resume(resm),
        .cmd_other(other), .prot_mask(prot), .busy(busy_t), .window_open(win_t),
        .suspended(susd_t), .cur_sector(cur_t), .pre_prog(pre_t), .done(done_t),
        .timeout_err(tmo_t));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic p_sec(input int s);
        sec = 1'b1; sector = 3'(s); tick(); sec = 1'b0;
    endtask
    task automatic p_susp();  susp = 1'b1;  tick(); susp = 1'b0;  endtask
    task automatic p_resm();  resm = 1'b1;  tick(); resm = 1'b0;  endtask
    task automatic p_other(); other = 1'b1; tick(); other = 1'b0; endtask
    task automatic p_chip();  chip = 1'b1;  tick(); chip = 1'b0;  endtask

    task automatic clean();
        p_other(); tick();
    endtask

    function automatic int nth_bit(input logic [7:0] m, input int k);
        int c = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                if (c == k) return i;
                c++;
            end
        end
        return 0;
    endfunction

    // wait for done; returns the sample index at which it is seen
    task automatic wait_done(input int start, output int at);
        int idx = start;
        while (!done && idx < 400) begin
            tick();
            idx++;
        end
        at = idx;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog R6 done never reached actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int at;
        logic [7:0] work;
        int n;
        logic bad;
        logic [31:0] obs_b, exp_b;
        logic [31:0] o, e;
        logic seen;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: everything quiet out of reset
        chk("R1 reset state", {busy, win, susd, cur, pre, done, tmo}, 32'd0);

        // R3 R4 R5 R6 R2: sweep every selection under three protection masks
        for (int pi = 0; pi < 3; pi++) begin
            prot = (pi == 0) ? 8'h00 : (pi == 1) ? 8'hA5 : 8'hFF;
            for (int s = 1; s < 256; s++) begin
                clean();
                for (int b = 7; b >= 0; b--) if (s[b]) p_sec(b);
                work = 8'(s) & ~prot;
                n = $countones(work);
                bad = 1'b0; obs_b = '0; exp_b = '0;
                for (int t = 0; t <= W + n * T; t++) begin
                    e = '0;
                    if (t < W) begin
                        e[6] = 1'b1;
                    end else if (t - W < n * T) begin
                        e[7]   = 1'b1;
                        e[4:2] = 3'(nth_bit(work, (t - W) / T));
                        e[0]   = ((t - W) % T) < PRE;
                    end else begin
                        e[5] = 1'b1;
                    end
                    o = {24'd0, busy, win, done, cur, 1'b0, pre};
                    if (o !== e && !bad) begin
                        bad = 1'b1;
                        obs_b = (32'(s) << 16) | (32'(t) << 8) | o;
                        exp_b = (32'(s) << 16) | (32'(t) << 8) | e;
                    end
                    tick();
                end
                chk("R3 R4 R5 R6 sweep sel/t/outputs", obs_b, exp_b);
            end
        end
        prot = 8'h00;
        chk("R11 no timeout within budget", 32'(tmo), 32'd0);

        // R13: write in the last open cycle restarts the window
        clean();
        p_sec(1);
        repeat (W - 1) tick();
        p_sec(4);
        chk("R13 window restarted", 32'(win), 32'd1);
        repeat (W - 1) tick();
        chk("R13 still open at end of new span", 32'(win), 32'd1);
        tick();
        chk("R13 erase starts on lowest sector", {busy, win, cur}, {1'b1, 1'b0, 3'd1});

        // R7: foreign commands discard the collection
        clean();
        p_sec(2);
        p_other();
        chk("R7 other closes window", {busy, win}, 32'd0);
        seen = 1'b0;
        for (int i = 0; i < W + T + 2; i++) begin
            tick();
            if (busy || done || win) seen = 1'b1;
        end
        chk("R7 nothing after other", 32'(seen), 32'd0);
        p_sec(2);
        p_chip();
        chk("R7 chip erase closes window", {busy, win}, 32'd0);
        seen = 1'b0;
        for (int i = 0; i < W + T + 2; i++) begin
            tick();
            if (busy || done || win) seen = 1'b1;
        end
        chk("R7 nothing after chip erase in window", 32'(seen), 32'd0);

        // R8: suspend inside the window
        clean();
        p_sec(5);
        p_sec(3);
        p_susp();
        chk("R8 suspended from window", {win, busy, susd, cur, pre}, {1'b0, 1'b1, 1'b1, 3'd3, 1'b1});
        repeat (10) tick();
        chk("R8 still frozen", {busy, susd, cur, pre}, {1'b1, 1'b1, 3'd3, 1'b1});
        p_resm();
        chk("R8 resume runs", 32'(susd), 32'd0);
        wait_done(0, at);
        chk("R8 done after two full sectors", 32'(at), 32'(2 * T));

        // R9: suspend during the erase
        clean();
        p_sec(0);
        repeat (W) tick();
        tick();
        p_susp();
        p_susp();
        repeat (LAT - 2) tick();
        chk("R9 not yet suspended at latency", 32'(susd), 32'd0);
        tick();
        chk("R9 suspended after latency", {susd, pre}, {1'b1, 1'b0});
        p_susp();
        chk("R9 repeat suspend ignored", 32'(susd), 32'd1);
        repeat (15) tick();
        p_resm();
        p_resm();
        wait_done(1, at);
        chk("R9 remaining cycles after resume", 32'(at), 32'(T - (1 + LAT + 1)));

        // R10: chip erase with sectors 0 and 7 protected, suspend ignored
        clean();
        prot = 8'h81;
        p_chip();
        chk("R10 chip erase starts at once", {busy, win, cur}, {1'b1, 1'b0, 3'd1});
        p_susp();
        chk("R10 suspend ignored", 32'(susd), 32'd0);
        wait_done(1, at);
        chk("R10 six sectors processed", 32'(at), 32'(6 * T));
        prot = 8'h00;

        // R11: per-sector budget on the instance with a short budget
        clean();
        p_sec(2);
        repeat (W) tick();
        repeat (3) tick();
        chk("R11 timeout raised", {tmo_t, busy_t, done_t}, {1'b1, 1'b0, 1'b0});
        p_sec(4);
        repeat (W + 6) tick();
        chk("R11 flag sticky across erase", 32'(tmo_t), 32'd1);
        p_other();
        chk("R11 reset command clears flag", 32'(tmo_t), 32'd0);

        // R12: abort while running and while suspended
        clean();
        p_sec(3);
        repeat (W + 2) tick();
        p_other();
        chk("R12 abort while running", {busy, win}, 32'd0);
        seen = 1'b0;
        for (int i = 0; i < T + 2; i++) begin
            tick();
            if (busy || done) seen = 1'b1;
        end
        chk("R12 no done after abort", 32'(seen), 32'd0);
        p_sec(3);
        p_susp();
        p_other();
        chk("R12 abort while suspended", {busy, susd}, 32'd0);
        p_resm();
        tick();
        chk("R12 resume after abort ignored", {busy, done}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule